// File: doc/BRIEF.md
# Serial Memory Target on a Two-Wire Bus

This block is a two-wire bus target that behaves like a small byte-wide nonvolatile memory. It watches the clock line and the data line of an open-drain bus, and it answers by pulling the data line low, either to acknowledge or to send a zero data bit. The storage is a register array. Its size is set by a parameter: 256 bytes in the narrow build and 512 bytes in the wide build.

A bus master addresses the block with a device-select byte. The block matches that byte against three strap pins. The master can then write one byte or a whole page, or read from the internal address pointer. It can also load the pointer with a dummy write and read from there after a repeated START, and it can stream reads across the whole array.

A write-protect pin guards the upper half of the array. After each write transfer the block models an internal write cycle, and during that cycle it does not acknowledge its device-select byte. This lets the master poll until the write has finished.

Top module: `serial_mem_target`

## Requirements
- R1: The device-select byte carries the code 1010 in bits 7:4, three extension bits in bits 3:1 and the direction in bit 0 (1 = read). In the narrow build, bits 3:1 must equal strap_i[2:0]. On a match the block holds sda_pull_o high through the 9th clock of that byte. On a mismatch it gives no acknowledge and ignores the bus until the next START.
- R2: In the wide build (512 bytes), only bits 3:2 are compared with strap_i[2:1], and strap_i[0] is ignored. Bit 1 of a write-mode device-select byte becomes address bit 8 when the word address byte that follows is loaded.
- R3: Writing a device-select byte (write mode), then a word address, then a data byte stores that data byte at the addressed location. Every one of those bytes is acknowledged.
- R4: Successive data bytes of one write transfer go to successive addresses. The address wraps within its 16-byte page, so bytes beyond 16 overwrite the earlier bytes of the same page, and locations outside the page are left unchanged.
- R5: wp_i is sampled as each data byte completes. If wp_i is high and the target address lies in the upper half of the array, that byte is not acknowledged, it is not stored, and the rest of the transfer is ignored. Writes to the lower half are still accepted while wp_i is high.
- R6: A STOP that follows at least one accepted data byte starts an internal write cycle of WR_CYCLES clocks. During that cycle a matching device-select byte is not acknowledged. After the cycle it is acknowledged again.
- R7: A read-mode device-select byte with no address phase returns the byte at the internal pointer. The pointer holds the address after the last byte written or read, or the word address that was loaded.
- R8: A write-mode device-select byte and a word address, followed by a repeated START and a read-mode device-select byte, returns the byte at the loaded address.
- R9: While the master acknowledges read bytes, the block returns consecutive locations and wraps from the last location of the whole array to 0.
- R10: When the master answers a read byte with NoACK, the block releases SDA and stays silent. After the following STOP, sda_pull_o is low.
- R11: After reset every location reads 0xFF and sda_pull_o is low.
- R12: A START (data falling while the clock is high) or a STOP (data rising while the clock is high) aborts any transfer at any bit. A START restarts device-select reception. A data byte that was cut short is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND result) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 3 | Device address strap pins |
| wp_i | input | 1 | Write protect for the upper half of the array |

## Verification
The bench places two instances on one shared bus: a wide build (WIDE_ARRAY=1, strap 3'b011) and a narrow build (WIDE_ARRAY=0, strap 3'b110). This puts both ways of matching the extension bits within reach at once: address bit 8 carried in the device-select byte, the ignored strap bit, and device-select bytes that neither instance may claim. WR_CYCLES is set to 400. A poll issued right after a STOP therefore lands inside the write cycle and must be refused, and a later poll must be acknowledged. The 512-byte array brings within reach both the wrap of a page in the upper half and a sequential read that wraps across the end of the array.

// File: rtl/smt_pkg.sv
package smt_pkg;

    // Fixed device-select code in the upper nibble of the select byte.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Transfer phase of the target.
    typedef enum logic [2:0] {
        PH_IDLE,   // ignoring the bus until a START
        PH_DSEL,   // receiving the device-select byte
        PH_WADR,   // receiving the word address
        PH_WDAT,   // receiving write data bytes
        PH_RDAT,   // shifting out a read byte
        PH_MACK    // master acknowledge slot after a read byte
    } phase_e;

endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int HW = STAGES + 1;

    typedef struct packed {
        logic [HW-1:0] scl_h;
        logic [HW-1:0] sda_h;
    } hist_t;

    hist_t h_q, h_d;

    logic scl_lvl, scl_prev, sda_lvl, sda_prev;

    always_comb begin
        h_d       = h_q;
        h_d.scl_h = {h_q.scl_h[HW-2:0], scl_i};
        h_d.sda_h = {h_q.sda_h[HW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.scl_h <= '1;
            h_q.sda_h <= '1;
        end else begin
            h_q <= h_d;
        end
    end

    assign scl_lvl  = h_q.scl_h[STAGES-1];
    assign scl_prev = h_q.scl_h[STAGES];
    assign sda_lvl  = h_q.sda_h[STAGES-1];
    assign sda_prev = h_q.sda_h[STAGES];

    assign sda_lvl_o  = sda_lvl;
    assign scl_rise_o = scl_lvl & ~scl_prev;
    assign scl_fall_o = ~scl_lvl & scl_prev;
    assign start_o    = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_o     = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smt_byte_array.sv
module smt_byte_array #(
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R3: an accepted byte is present in the array on the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/smt_busy_timer.sv
module smt_busy_timer #(
    parameter int WR_CYCLES = 2000,
    localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic busy_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (kick_i) begin
            t_d.cnt = CNT_W'(WR_CYCLES);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o = (t_q.cnt != '0);

    // R6: a kick always opens the busy window on the next cycle
    p_kick_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> busy_o);

    // R6: the window drains one step per clock
    p_drain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !kick_i) |=> (t_q.cnt == $past(t_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int WIDE_ARRAY  = 1,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int ADDR_W = (WIDE_ARRAY != 0) ? 9 : 8;
    localparam int PG_W   = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e            ph;
        logic [3:0]        bitn;   // receive: bits taken (9 = ack slot); read: bits sent
        logic [7:0]        sh;
        logic              rw;
        logic              hi;     // address bit 8 carried by the select byte
        logic [ADDR_W-1:0] addr;
        logic              nack;
        logic              pend;   // accepted write data awaiting STOP
        logic              pull;
    } tgt_t;

    tgt_t st_q, st_d;

    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, kick, mem_we, ext_ok, dev_hit;
    logic [7:0] rd_data;

    smt_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    smt_busy_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick),
        .busy_o (busy)
    );

    smt_byte_array #(.ADDR_W(ADDR_W)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (st_q.addr),
        .wdata_i (st_q.sh),
        .raddr_i (st_q.addr),
        .rdata_o (rd_data)
    );

    generate
        if (WIDE_ARRAY != 0) begin : g_wide
            logic unused_strap_lsb;
            assign unused_strap_lsb = strap_i[0];
            assign ext_ok = (st_q.sh[3:2] == strap_i[2:1]);
        end else begin : g_narrow
            assign ext_ok = (st_q.sh[3:1] == strap_i);
        end
    endgenerate

    assign dev_hit = (st_q.sh[7:4] == DEV_CODE) && ext_ok && !busy;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        kick   = 1'b0;
        if (start_ev) begin
            st_d.ph   = PH_DSEL;
            st_d.bitn = 4'd0;
            st_d.pull = 1'b0;
        end else if (stop_ev) begin
            st_d.ph   = PH_IDLE;
            st_d.bitn = 4'd0;
            st_d.pull = 1'b0;
            if (st_q.pend) begin
                kick      = 1'b1;
                st_d.pend = 1'b0;
            end
        end else if (scl_rise) begin
            case (st_q.ph)
                PH_DSEL, PH_WADR, PH_WDAT: begin
                    if (st_q.bitn < 4'd8) begin
                        st_d.sh   = {st_q.sh[6:0], sda_lvl};
                        st_d.bitn = st_q.bitn + 4'd1;
                    end
                end
                PH_MACK: st_d.nack = sda_lvl;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (st_q.ph)
                PH_DSEL, PH_WADR, PH_WDAT: begin
                    if (st_q.bitn == 4'd8) begin
                        st_d.bitn = 4'd9;
                        if (st_q.ph == PH_DSEL) begin
                            if (dev_hit) begin
                                st_d.pull = 1'b1;
                                st_d.rw   = st_q.sh[0];
                                st_d.hi   = st_q.sh[1];
                            end else begin
                                st_d.ph   = PH_IDLE;
                                st_d.bitn = 4'd0;
                            end
                        end else if (st_q.ph == PH_WADR) begin
                            st_d.pull = 1'b1;
                            st_d.addr = ADDR_W'({st_q.hi, st_q.sh});
                        end else if (wp_i && st_q.addr[ADDR_W-1]) begin
                            st_d.ph   = PH_IDLE;
                            st_d.bitn = 4'd0;
                        end else begin
                            mem_we    = 1'b1;
                            st_d.pull = 1'b1;
                            st_d.pend = 1'b1;
                            st_d.addr = {st_q.addr[ADDR_W-1:PG_W],
                                         st_q.addr[PG_W-1:0] + PG_W'(1)};
                        end
                    end else if (st_q.bitn == 4'd9) begin
                        st_d.pull = 1'b0;
                        st_d.bitn = 4'd0;
                        if (st_q.ph == PH_DSEL && st_q.rw) begin
                            st_d.ph   = PH_RDAT;
                            st_d.sh   = rd_data;
                            st_d.pull = ~rd_data[7];
                            st_d.addr = st_q.addr + ADDR_W'(1);
                        end else if (st_q.ph == PH_DSEL) begin
                            st_d.ph = PH_WADR;
                        end else begin
                            st_d.ph = PH_WDAT;
                        end
                    end
                end
                PH_RDAT: begin
                    if (st_q.bitn == 4'd7) begin
                        st_d.ph   = PH_MACK;
                        st_d.pull = 1'b0;
                        st_d.bitn = 4'd0;
                    end else begin
                        st_d.sh   = {st_q.sh[6:0], 1'b1};
                        st_d.pull = ~st_q.sh[6];
                        st_d.bitn = st_q.bitn + 4'd1;
                    end
                end
                PH_MACK: begin
                    if (st_q.nack) begin
                        st_d.ph = PH_IDLE;
                    end else begin
                        st_d.ph   = PH_RDAT;
                        st_d.bitn = 4'd0;
                        st_d.sh   = rd_data;
                        st_d.pull = ~rd_data[7];
                        st_d.addr = st_q.addr + ADDR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.bitn <= 4'd0;
            st_q.sh   <= 8'hFF;
            st_q.rw   <= 1'b0;
            st_q.hi   <= 1'b0;
            st_q.addr <= '0;
            st_q.nack <= 1'b1;
            st_q.pend <= 1'b0;
            st_q.pull <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull_o = st_q.pull;

    // R12: the bit counter never leaves the 0..9 range
    p_bitn_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bitn <= 4'd9);

    // R12: a START always lands in select reception at bit zero
    p_start_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q.ph == PH_DSEL && st_q.bitn == 4'd0 && !sda_pull_o));

    // R10: the data line is free after a STOP
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull_o);

    // R4: a write never moves the pointer out of its page
    p_page_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (st_q.addr[ADDR_W-1:PG_W] == $past(st_q.addr[ADDR_W-1:PG_W])));

    // R5: no store into the upper half while protect is high
    p_wp_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_i && st_q.addr[ADDR_W-1]));

    // R6: a select acknowledge never overlaps the write cycle
    p_busy_noack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DSEL && st_q.bitn == 4'd9 && sda_pull_o) |-> !busy);

endmodule

// File: tb/serial_mem_target_tb_top.sv
module serial_mem_target_tb_top;

    localparam int H = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp    = 1'b0;
    logic pull_big, pull_small, bus_sda;

    assign bus_sda = sda_m & ~pull_big & ~pull_small;

    serial_mem_target #(.WIDE_ARRAY(1), .WR_CYCLES(400)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
        .sda_pull_o(pull_big), .strap_i(3'b011), .wp_i(wp));

    serial_mem_target #(.WIDE_ARRAY(0), .WR_CYCLES(400)) dut_s (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
        .sda_pull_o(pull_small), .strap_i(3'b110), .wp_i(wp));

    // behavioural reference state
    logic [7:0] ref_big [512];
    logic [7:0] ref_small [256];
    int ptr_big = 0;
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic m_clock(input logic b, output logic seen);
        sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        seen = bus_sda;
        scl_m = 1'b0; wt(2);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_clock(b[i], s);
        m_clock(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_clock(1'b1, s);
            d[i] = s;
        end
        m_clock(~mack, s);
    endtask

    task automatic poll(input logic [7:0] dsel, input string req);
        logic ak;
        int tries = 0;
        m_start(); m_wbyte(dsel, ak);
        chk_eq({req, " select refused in write cycle"}, int'(ak), 0);
        while (!ak && tries < 8) begin
            m_stop(); m_start(); m_wbyte(dsel, ak);
            tries++;
        end
        chk_eq({req, " select accepted after write cycle"}, int'(ak), 1);
        m_stop();
    endtask

    task automatic wr_big(input int a, input int first, input int cnt, input string req);
        logic ak;
        int pos;
        bit any = 0;
        logic [7:0] dsel;
        dsel = 8'hA4 | 8'((a >> 7) & 2);
        m_start();
        m_wbyte(dsel, ak); chk_eq({req, " select ack"}, int'(ak), 1);
        m_wbyte(8'(a), ak); chk_eq({req, " word ack"}, int'(ak), 1);
        ptr_big = a;
        for (int i = 0; i < cnt; i++) begin
            pos = (a & 'h1F0) | ((a + i) & 15);
            m_wbyte(8'(first + i), ak);
            chk_eq({req, " data ack"}, int'(ak), (wp && pos >= 256) ? 0 : 1);
            if (wp && pos >= 256) break;
            ref_big[pos] = 8'(first + i);
            ptr_big = (a & 'h1F0) | ((a + i + 1) & 15);
            any = 1;
        end
        m_stop();
        if (any) poll(dsel, "R6");
    endtask

    task automatic rd_big(input int a, input int cnt, input string req);
        logic ak;
        logic [7:0] d;
        m_start();
        m_wbyte(8'hA4 | 8'((a >> 7) & 2), ak); chk_eq({req, " select ack"}, int'(ak), 1);
        m_wbyte(8'(a), ak); chk_eq({req, " word ack"}, int'(ak), 1);
        m_start();
        m_wbyte(8'hA5, ak); chk_eq({req, " read select ack"}, int'(ak), 1);
        for (int i = 0; i < cnt; i++) begin
            m_rbyte(i != cnt - 1, d);
            chk_eq(req, int'(d), int'(ref_big[(a + i) & 511]));
        end
        m_stop();
        ptr_big = (a + cnt) & 511;
        chk_eq("R10 line released after stop", int'(pull_big | pull_small), 0);
    endtask

    task automatic cur_big(input string req);
        logic ak;
        logic [7:0] d;
        m_start();
        m_wbyte(8'hA5, ak); chk_eq({req, " select ack"}, int'(ak), 1);
        m_rbyte(1'b0, d);
        chk_eq(req, int'(d), int'(ref_big[ptr_big]));
        ptr_big = (ptr_big + 1) & 511;
        m_stop();
    endtask

    task automatic nosel(input logic [7:0] dsel, input string req);
        logic ak;
        m_start(); m_wbyte(dsel, ak);
        chk_eq(req, int'(ak), 0);
        m_stop();
    endtask

    initial begin
        logic ak;
        logic [7:0] d;
        logic s;
        for (int i = 0; i < 512; i++) ref_big[i] = 8'hFF;
        for (int i = 0; i < 256; i++) ref_small[i] = 8'hFF;
        wt(5); rst_n = 1'b1; wt(5);

        chk_eq("R11 line released at reset", int'(pull_big | pull_small), 0);
        cur_big("R11 R7 erased byte at pointer");

        nosel(8'hA8, "R1 extension mismatch gets no ack");
        nosel(8'hAE, "R1 narrow strap compare on all three bits");
        nosel(8'h26, "R1 wrong device code gets no ack");

        wr_big('h125, 'h3C, 1, "R3 byte write upper");
        rd_big('h125, 1, "R8 selective read");
        cur_big("R7 current read after selective read");
        rd_big('h025, 1, "R2 select bit 1 is address bit 8");

        wr_big('h11E, 'h40, 18, "R4 page write wrap");
        rd_big('h110, 17, "R4 R9 page contents and neighbour");

        wp = 1'b1;
        wr_big('h150, 'h11, 1, "R5 protected upper byte");
        wr_big('h050, 'h22, 1, "R5 lower half writable");
        wp = 1'b0;
        rd_big('h150, 1, "R5 rejected byte absent");
        rd_big('h050, 1, "R5 lower byte stored");

        // R5: protect sampled per data byte
        m_start();
        m_wbyte(8'hA6, ak); chk_eq("R5 select ack", int'(ak), 1);
        m_wbyte(8'h60, ak); chk_eq("R5 word ack", int'(ak), 1);
        m_wbyte(8'h55, ak); chk_eq("R5 first byte before protect", int'(ak), 1);
        ref_big['h160] = 8'h55;
        wp = 1'b1;
        m_wbyte(8'h66, ak); chk_eq("R5 second byte after protect", int'(ak), 0);
        m_stop();
        wp = 1'b0;
        poll(8'hA6, "R6 after partial page");
        rd_big('h160, 2, "R5 per-byte protect result");

        wr_big('h1FF, 'h5A, 1, "R3 last location");
        wr_big('h000, 'hA5, 1, "R3 first location");
        rd_big('h1FE, 4, "R9 sequential wrap at array end");

        // narrow instance, its own strap code
        m_start();
        m_wbyte(8'hAC, ak); chk_eq("R1 narrow select ack", int'(ak), 1);
        m_wbyte(8'h80, ak); chk_eq("R3 narrow word ack", int'(ak), 1);
        m_wbyte(8'h77, ak); chk_eq("R3 narrow data ack", int'(ak), 1);
        ref_small['h80] = 8'h77;
        m_stop();
        poll(8'hAC, "R6 narrow");
        m_start();
        m_wbyte(8'hAC, ak); m_wbyte(8'h80, ak);
        m_start();
        m_wbyte(8'hAD, ak); chk_eq("R8 narrow read select ack", int'(ak), 1);
        m_rbyte(1'b0, d); chk_eq("R8 narrow selective read", int'(d), int'(ref_small['h80]));
        m_stop();
        rd_big('h080, 1, "R1 other device untouched");

        // R12: START inside a data byte
        m_start();
        m_wbyte(8'hA4, ak); m_wbyte(8'h30, ak);
        ptr_big = 'h030;
        for (int i = 0; i < 3; i++) m_clock(1'b0, s);
        m_start();
        m_wbyte(8'hA5, ak); chk_eq("R12 select after abort by START", int'(ak), 1);
        m_rbyte(1'b0, d); chk_eq("R12 cut byte not stored", int'(d), int'(ref_big['h030]));
        ptr_big = 'h031;
        m_stop();

        // R12: STOP inside a data byte, no write cycle follows
        m_start();
        m_wbyte(8'hA4, ak); m_wbyte(8'h31, ak);
        ptr_big = 'h031;
        for (int i = 0; i < 4; i++) m_clock(1'b0, s);
        m_stop();
        cur_big("R12 R7 no write cycle after aborted byte");
        chk_eq("R10 released at end", int'(pull_big | pull_small), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule